// File: doc/BRIEF.md
# Bit-Serial Variable-Precision Multiply-Accumulate Lane

This block multiplies a 16-bit two's complement weight, held in parallel, by an unsigned activation that arrives one bit per clock, most significant bit first. There is no multiplier in the datapath. In each cycle the sign-extended weight is gated by the current activation bit through a row of AND gates. A partial-product register is doubled and the gated weight is added to it. When the last bit has been consumed, the product is either added into a 40-bit result register or replaces it.

The number of activation bits per operation is a runtime setting from 1 to 16, so one operation takes as many cycles as the chosen precision. This lets a layer with narrow activations finish proportionally sooner. An accumulate-enable input, sampled at start, lets a sequence of weight/activation pairs sum into the same result, as a dot product needs.

The weight and the precision are each held in a register. A write to either register in the same cycle as a start is used by the operation that starts in that cycle. A write while an operation runs only affects later operations.

Top module: `bsmac_lane`

## Requirements
- R1: While `rst` is high and after it falls, `result` is 0 and `result_valid` is 0. The held weight resets to 0 and the held precision setting resets to 0.
- R2: An operation started with weight W, effective precision N and activation bits b(N-1)..b0 (b(N-1) on `act_bit` in the start cycle, then one bit per following cycle) produces the product of W, sign-extended to 40 bits, and the unsigned value of those bits.
- R3: `result_valid` is high for exactly one cycle, N cycles after the start cycle. It is never high at any other time.
- R4: A precision setting of 0 acts as 1 bit, and any setting above 16 acts as 16 bits.
- R5: A precision written with `cfg_write` stays in force for later operations. A write in the same cycle as `start` applies to that operation. A write during a run affects only later operations.
- R6: A weight written with `wgt_load` stays in force for later operations. A load in the same cycle as `start` applies to that operation. A load during a run affects only later operations.
- R7: When `acc_en` is 1 in the start cycle, the product is added to the value `result` held before. When it is 0, the product replaces it.
- R8: A `start` during a run abandons that run: it never raises `result_valid`, and the new operation proceeds normally.
- R9: `result` changes only in a cycle where `result_valid` is high. Between completions it holds, whatever the serial input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wgt_load | input | 1 | Write `wgt_in` into the weight register |
| wgt_in | input | 16 | Two's complement weight |
| cfg_write | input | 1 | Write `cfg_prec` into the precision register |
| cfg_prec | input | 5 | Activation bit count (0 means 1, above 16 means 16) |
| start | input | 1 | Begin an operation; `act_bit` carries its first bit |
| act_bit | input | 1 | Serial activation bit, most significant first |
| acc_en | input | 1 | Sampled at start: add product into result instead of replacing |
| result | output | 40 | Accumulated signed result |
| result_valid | output | 1 | One-cycle pulse when an operation completes |

## Verification
The configuration path and the serial datapath can act in the same cycle. A weight load or a precision write can coincide with a start, and a load or write can also land in the middle of a run. The bench provokes both cases. It judges the same-cycle case by checking that the completing product uses the new weight and finishes on the new cycle count. It judges the mid-run case by checking that the running product keeps the old operands and that the next operation, issued without a fresh write, uses the new ones. A back-to-back start in the completion cycle of the previous operation is also exercised, together with a start that aborts a run partway.

// File: rtl/bsmac_pkg.sv
`timescale 1ns/1ps
package bsmac_pkg;
    localparam int WGT_W    = 16;
    localparam int ACC_W    = 40;
    localparam int MAX_PREC = 16;
    localparam int PREC_W   = $clog2(MAX_PREC + 1);

    typedef logic [WGT_W-1:0]  wgt_t;
    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [PREC_W-1:0] prec_t;

    // sequencer state: running flag and bits still to consume
    typedef struct packed {
        logic  busy;
        prec_t left;
    } seq_t;

    // operands latched for the duration of one operation
    typedef struct packed {
        wgt_t wgt;
        logic accum;
    } opnd_t;

    function automatic prec_t eff_prec(prec_t p);
        if (p == '0) return prec_t'(1);
        if (p > prec_t'(MAX_PREC)) return prec_t'(MAX_PREC);
        return p;
    endfunction

    function automatic acc_t sext_w(wgt_t w);
        return {{(ACC_W-WGT_W){w[WGT_W-1]}}, w};
    endfunction
endpackage

// File: rtl/bsmac_cfg.sv
`timescale 1ns/1ps
module bsmac_cfg
    import bsmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wgt_load,
    input  wgt_t  wgt_in,
    input  logic  cfg_write,
    input  prec_t cfg_prec,
    output wgt_t  wgt_eff,
    output prec_t n_eff
);
    wgt_t  wgt_q;
    prec_t prec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wgt_q  <= '0;
            prec_q <= '0;
        end else begin
            if (wgt_load)  wgt_q  <= wgt_in;
            if (cfg_write) prec_q <= cfg_prec;
        end
    end

    // a write in the start cycle bypasses the register
    assign wgt_eff = wgt_load  ? wgt_in : wgt_q;
    assign n_eff   = eff_prec(cfg_write ? cfg_prec : prec_q);
endmodule

// File: rtl/bsmac_ctrl.sv
`timescale 1ns/1ps
module bsmac_ctrl
    import bsmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  prec_t n_eff,
    output logic  step,
    output logic  done,
    output logic  valid
);
    seq_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        step  = seq_q.busy && !start;
        done  = 1'b0;
        if (start) begin
            seq_d.busy = (n_eff != prec_t'(1));
            seq_d.left = n_eff - prec_t'(1);
            done       = (n_eff == prec_t'(1));
        end else if (seq_q.busy) begin
            seq_d.left = seq_q.left - prec_t'(1);
            if (seq_q.left == prec_t'(1)) begin
                seq_d.busy = 1'b0;
                done       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
            valid <= 1'b0;
        end else begin
            seq_q <= seq_d;
            valid <= done;
        end
    end
endmodule

// File: rtl/bsmac_datapath.sv
`timescale 1ns/1ps
module bsmac_datapath
    import bsmac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic step,
    input  logic done,
    input  logic act_bit,
    input  logic acc_en,
    input  wgt_t wgt_eff,
    output acc_t result
);
    opnd_t run_q;
    acc_t  part_q;
    acc_t  res_q;
    acc_t  wx;
    acc_t  pp;
    acc_t  part_nx;
    wgt_t  w_cur;
    logic  acc_cur;

    assign w_cur   = start ? wgt_eff : run_q.wgt;
    assign acc_cur = start ? acc_en  : run_q.accum;
    assign wx      = sext_w(w_cur);

    // partial product: one AND gate per accumulator bit
    for (genvar i = 0; i < ACC_W; i++) begin : g_gate
        assign pp[i] = wx[i] & act_bit;
    end

    assign part_nx = start ? pp : ({part_q[ACC_W-2:0], 1'b0} + pp);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            part_q <= '0;
            res_q  <= '0;
        end else begin
            if (start)         run_q  <= '{wgt: wgt_eff, accum: acc_en};
            if (start || step) part_q <= part_nx;
            if (done)          res_q  <= (acc_cur ? res_q : '0) + part_nx;
        end
    end

    assign result = res_q;
endmodule

// File: rtl/bsmac_lane.sv
`timescale 1ns/1ps
module bsmac_lane
    import bsmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wgt_load,
    input  logic [15:0] wgt_in,
    input  logic        cfg_write,
    input  logic [4:0]  cfg_prec,
    input  logic        start,
    input  logic        act_bit,
    input  logic        acc_en,
    output logic [39:0] result,
    output logic        result_valid
);
    wgt_t  wgt_eff;
    prec_t n_eff;
    logic  step;
    logic  done;

    bsmac_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wgt_load  (wgt_load),
        .wgt_in    (wgt_in),
        .cfg_write (cfg_write),
        .cfg_prec  (cfg_prec),
        .wgt_eff   (wgt_eff),
        .n_eff     (n_eff)
    );

    bsmac_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .n_eff (n_eff),
        .step  (step),
        .done  (done),
        .valid (result_valid)
    );

    bsmac_datapath u_dp (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .step    (step),
        .done    (done),
        .act_bit (act_bit),
        .acc_en  (acc_en),
        .wgt_eff (wgt_eff),
        .result  (result)
    );
endmodule

// File: rtl/bsmac_lane_chk.sv
`timescale 1ns/1ps
module bsmac_lane_chk
    import bsmac_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wgt_load,
    input logic [15:0] wgt_in,
    input logic        cfg_write,
    input logic [4:0]  cfg_prec,
    input logic        start,
    input logic        act_bit,
    input logic        acc_en,
    input logic [39:0] result,
    input logic        result_valid
);
    logic  live;
    logic  armed;
    prec_t cnt;
    prec_t n_l;
    prec_t prec_c;
    wgt_t  wgt_c;
    wgt_t  w_l;
    logic  acc_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= 1'b0; armed <= 1'b0; cnt <= '0; n_l <= '0;
            prec_c <= '0; wgt_c <= '0; w_l <= '0; acc_l <= 1'b0;
        end else begin
            live <= 1'b1;
            if (wgt_load)  wgt_c  <= wgt_in;
            if (cfg_write) prec_c <= cfg_prec;
            if (start) begin
                armed <= 1'b1;
                cnt   <= prec_t'(1);
                n_l   <= eff_prec(cfg_write ? cfg_prec : prec_c);
                w_l   <= wgt_load ? wgt_in : wgt_c;
                acc_l <= acc_en;
            end else if (armed) begin
                if (cnt == n_l) armed <= 1'b0;
                cnt <= cnt + prec_t'(1);
            end
        end
    end

    // R3: valid only at the Nth cycle after the latest start
    p_valid_timing_r3: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (armed && cnt == n_l));

    // R3: every unaborted operation completes on time
    p_completes_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && cnt == n_l) |-> result_valid);

    // R9: result moves only with a completion pulse
    p_hold_r9: assert property (@(posedge clk) disable iff (rst || !live)
        !result_valid |-> (result == $past(result)));

    // R2: a zero weight without accumulation yields zero
    p_zero_weight_r2: assert property (@(posedge clk) disable iff (rst)
        (result_valid && !acc_l && w_l == '0) |-> (result == '0));

    // R4: setting of zero (or one) finishes in a single cycle
    p_single_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (start && eff_prec(cfg_write ? cfg_prec : prec_c) == prec_t'(1)) |=> result_valid);
endmodule

bind bsmac_lane bsmac_lane_chk u_chk (.*);

// File: tb/bsmac_lane_test.sv
`timescale 1ns/1ps
module bsmac_lane_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wgt_load;
    logic [15:0] wgt_in;
    logic        cfg_write;
    logic [4:0]  cfg_prec;
    logic        start;
    logic        act_bit;
    logic        acc_en;
    logic [39:0] result;
    logic        result_valid;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bsmac_lane uut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [39:0] prod(input logic [15:0] w, input int n, input logic [15:0] a);
        longint mask = (longint'(1) << n) - 1;
        longint e    = longint'($signed(w)) * (longint'(a) & mask);
        return e[39:0];
    endfunction

    // one operation; n is the effective precision the bench expects
    task automatic op(input logic [15:0] w, input bit ld, input bit cw, input logic [4:0] pc,
                      input int n, input logic [15:0] a, input bit acc, input string req,
                      input bit midld, input logic [15:0] midw,
                      input bit midcw, input logic [4:0] midpc);
        for (int k = 0; k < n; k++) begin
            start     = (k == 0);
            wgt_load  = (ld && k == 0) || (midld && k == 1);
            wgt_in    = (k == 1) ? midw : w;
            cfg_write = (cw && k == 0) || (midcw && k == 1);
            cfg_prec  = (k == 1) ? midpc : pc;
            act_bit   = a[n-1-k];
            acc_en    = acc;
            @(posedge clk);
            @(negedge clk);
            start = 0; wgt_load = 0; cfg_write = 0;
            if (k < n - 1)
                check(result_valid == 1'b0, "R3", {req, " early valid"}, 40'(result_valid), 0);
        end
        check(result_valid == 1'b1, "R3", {req, " valid at N"}, 40'(result_valid), 1);
    endtask

    task automatic t_reset;
        rst = 1; wgt_load = 0; wgt_in = 0; cfg_write = 0; cfg_prec = 0;
        start = 0; act_bit = 0; acc_en = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(result == 0, "R1", "result in reset", result, 0);
        check(result_valid == 0, "R1", "valid in reset", 40'(result_valid), 0);
        rst = 0;
        @(negedge clk);
        check(result == 0 && result_valid == 0, "R1", "after reset", result, 0);
        // held weight 0 and precision 0 (one bit): single cycle, zero product
        op(16'h7777, 0, 0, 0, 1, 16'h1, 0, "R1", 0, 0, 0, 0);
        check(result == 0, "R1", "reset weight is zero", result, 0);
    endtask

    task automatic t_basic;
        op(16'h0123, 1, 1, 5'd8, 8, 16'h00A5, 0, "R2", 0, 0, 0, 0);
        check(result == prod(16'h0123, 8, 16'h00A5), "R2", "8-bit product", result, prod(16'h0123, 8, 16'h00A5));
        op(16'h8000, 1, 1, 5'd16, 16, 16'hFFFF, 0, "R2", 0, 0, 0, 0);
        check(result == prod(16'h8000, 16, 16'hFFFF), "R2", "min weight full act", result, prod(16'h8000, 16, 16'hFFFF));
        op(16'hFFFD, 1, 0, 0, 16, 16'h1234, 0, "R2", 0, 0, 0, 0);
        check(result == prod(16'hFFFD, 16, 16'h1234), "R2", "negative weight", result, prod(16'hFFFD, 16, 16'h1234));
    endtask

    task automatic t_clamp;
        op(16'hFFFB, 1, 1, 5'd0, 1, 16'h1, 0, "R4", 0, 0, 0, 0);
        check(result == prod(16'hFFFB, 1, 16'h1), "R4", "zero acts as one", result, prod(16'hFFFB, 1, 16'h1));
        op(16'h0321, 1, 1, 5'd31, 16, 16'hBEEF, 0, "R4", 0, 0, 0, 0);
        check(result == prod(16'h0321, 16, 16'hBEEF), "R4", "above 16 clamps", result, prod(16'h0321, 16, 16'hBEEF));
    endtask

    task automatic t_prec_persist;
        op(16'h0011, 1, 1, 5'd5, 5, 16'h001B, 0, "R5", 0, 0, 1, 5'd3);
        check(result == prod(16'h0011, 5, 16'h001B), "R5", "mid-run write ignored", result, prod(16'h0011, 5, 16'h001B));
        op(16'h0011, 0, 0, 0, 3, 16'h0006, 0, "R5", 0, 0, 0, 0);
        check(result == prod(16'h0011, 3, 16'h0006), "R5", "later op uses write", result, prod(16'h0011, 3, 16'h0006));
    endtask

    task automatic t_weight;
        op(16'h0040, 1, 1, 5'd6, 6, 16'h002D, 0, "R6", 1, 16'hFF00, 0, 0);
        check(result == prod(16'h0040, 6, 16'h002D), "R6", "mid-run load ignored", result, prod(16'h0040, 6, 16'h002D));
        op(16'h0000, 0, 0, 0, 6, 16'h0013, 0, "R6", 0, 0, 0, 0);
        check(result == prod(16'hFF00, 6, 16'h0013), "R6", "later op uses load", result, prod(16'hFF00, 6, 16'h0013));
    endtask

    task automatic t_acc;
        logic [39:0] s;
        op(16'h1234, 1, 1, 5'd12, 12, 16'h0ABC, 0, "R7", 0, 0, 0, 0);
        s = prod(16'h1234, 12, 16'h0ABC);
        op(16'hF00F, 1, 0, 0, 12, 16'h0F0F, 1, "R7", 0, 0, 0, 0);
        s = s + prod(16'hF00F, 12, 16'h0F0F);
        check(result == s, "R7", "accumulated sum", result, s);
        op(16'h0002, 1, 0, 0, 12, 16'h0003, 0, "R7", 0, 0, 0, 0);
        check(result == prod(16'h0002, 12, 16'h0003), "R7", "replace clears", result, prod(16'h0002, 12, 16'h0003));
    endtask

    task automatic t_restart;
        for (int k = 0; k < 3; k++) begin
            start = (k == 0); cfg_write = (k == 0); cfg_prec = 5'd8;
            wgt_load = (k == 0); wgt_in = 16'h7FFF; act_bit = 1'b1; acc_en = 0;
            @(posedge clk);
            @(negedge clk);
            start = 0; cfg_write = 0; wgt_load = 0;
            check(result_valid == 0, "R8", "no valid mid run", 40'(result_valid), 0);
        end
        op(16'h0009, 1, 1, 5'd4, 4, 16'h000B, 0, "R8", 0, 0, 0, 0);
        check(result == prod(16'h0009, 4, 16'h000B), "R8", "restart product", result, prod(16'h0009, 4, 16'h000B));
    endtask

    task automatic t_hold;
        logic [39:0] h;
        h = result;
        for (int k = 0; k < 6; k++) begin
            act_bit = k[0]; acc_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check(result_valid == 0, "R9", "idle valid", 40'(result_valid), 0);
            check(result == h, "R9", "idle hold", result, h);
        end
    endtask

    initial begin
        t_reset;
        t_basic;
        t_clamp;
        t_prec_persist;
        t_weight;
        t_acc;
        t_restart;
        t_hold;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule